// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit holds the interrupt cause register of a network controller together with the register that enables each cause. Single-cycle event pulses from the receive path, transmit path, remote DMA engine, tally counters and buffer-ring logic each set one status bit. The host reads the status register to find the cause of an interrupt. It acknowledges individual causes by writing ones to them, and it decides which causes may raise the interrupt line by writing the mask register.

The top bit of the status register is not an event bit. It follows controller state. It is raised when the controller enters its reset state or when the receive ring overflows. It is dropped when a start command arrives or when packets are taken off the ring. The host cannot write it, and it never raises the interrupt.

The seven event bits have no defined value at power-up, and software is expected to clear them by writing all ones. To model this, the unit loads the value on `init_status` while reset is asserted.

Top module: `irq_status_unit`

## Requirements
- R1: The status register is read at address 7h and the mask register at address Fh. `host_rdata` is registered: it shows, one clock after an address is presented, the register contents as they were before that edge's update. Any other address reads 00h. Reads have no side effects.
- R2: Event inputs map to status bits as follows: bit 0 packet received, bit 1 packet transmitted, bit 2 receive error, bit 3 transmit error, bit 4 overwrite warning, bit 5 counter overflow, bit 6 remote DMA complete. A one on `evt_set[i]` sets status bit i at the next clock edge.
- R3: A host write to 7h clears each event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R4: When an event pulse and a host clear reach the same bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly while at least one of status bits 0..6 is set and has its mask bit set. It is low while every such bit is clear.
- R6: A host write to Fh loads write-data bits 0..6 into the mask. Mask bit 7 always reads 0.
- R7: Status bit 7 becomes 1 after a cycle with `ctl_reset_enter` or `ring_overflow` high. It becomes 0 after a cycle with `ctl_start` or `ring_drained` high and neither set input high. Otherwise it holds its value. A set input wins over a clear input in the same cycle.
- R8: Host writes do not change status bit 7. Status bit 7 never drives `irq`, whatever the mask holds.
- R9: While `rst_n` is low, status bits 0..6 take the value of `init_status`, the mask clears to 00h, status bit 7 is 1, `host_rdata` is 00h and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_status | input | 7 | Arbitrary power-up value for event bits 0..6 |
| evt_set | input | 7 | One-cycle event pulses, one per event bit |
| ctl_reset_enter | input | 1 | Controller entered its reset state |
| ctl_start | input | 1 | Start command issued |
| ring_overflow | input | 1 | Receive buffer ring overflowed |
| ring_drained | input | 1 | One or more packets were removed from the ring |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, high while any unmasked event bit is set |

## Verification
The hardest case to reach is an event pulse and a write-one-to-clear hitting the same bit in the same cycle. The bench drives the event input and the host write together in one cycle and then reads the bit back. It also drives the set and clear controls of bit 7 together. Beyond these directed collisions, a long phase of random event pulses, host writes, mask changes and control pulses runs against a reference model that is checked on every clock.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int N_EVT     = 7;
    localparam int DATA_W    = N_EVT + 1;
    localparam int ADDR_W    = 4;
    localparam int STAT_ADDR = 7;
    localparam int MASK_ADDR = 15;

    localparam int B_RX_OK   = 0;
    localparam int B_TX_OK   = 1;
    localparam int B_RX_ERR  = 2;
    localparam int B_TX_ERR  = 3;
    localparam int B_OVWARN  = 4;
    localparam int B_CNT_OVF = 5;
    localparam int B_DMA_END = 6;
    localparam int B_RSTAT   = 7;
endpackage

// File: rtl/irq_evt_bits.sv
module irq_evt_bits #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] init_val,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] bits
);
    typedef struct packed {
        logic [N-1:0] bits;
    } evt_state_t;

    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set[i])
                st_d.bits[i] = 1'b1;
            else if (clr[i])
                st_d.bits[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.bits <= init_val;
        else
            st_q <= st_d;
    end

    assign bits = st_q.bits;

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((bits & $past(set)) == $past(set)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != '0) |=> ((bits & $past(clr & ~set)) == '0));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set == '0) && (clr == '0)) |=> $stable(bits));
endmodule

// File: rtl/irq_rst_flag.sv
module irq_rst_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic start,
    input  logic ovf,
    input  logic drained,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic raise, drop;

    always_comb begin
        raise = enter | ovf;
        drop  = start | drained;
        st_d  = st_q;
        if (raise)
            st_d.flag = 1'b1;
        else if (drop)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.flag <= 1'b1;
        else
            st_q <= st_d;
    end

    assign flag = st_q.flag;

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enter || ovf) |=> flag);
    p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((start || drained) && !enter && !ovf) |=> !flag);
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !drained && !enter && !ovf) |=> $stable(flag));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);
    typedef struct packed {
        logic [N-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we)
            st_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q.mask <= '0;
        else
            st_q <= st_d;
    end

    assign mask = st_q.mask;

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mask == $past(wdata)));
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mask));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int N_EV     = N_EVT,
    parameter int AW       = ADDR_W,
    parameter int ST_ADDR  = STAT_ADDR,
    parameter int MSK_ADDR = MASK_ADDR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] init_status,
    input  logic [N_EV-1:0] evt_set,
    input  logic            ctl_reset_enter,
    input  logic            ctl_start,
    input  logic            ring_overflow,
    input  logic            ring_drained,
    input  logic [AW-1:0]   host_addr,
    input  logic            host_wr,
    input  logic [N_EV:0]   host_wdata,
    output logic [N_EV:0]   host_rdata,
    output logic            irq
);
    localparam int DW = N_EV + 1;
    localparam logic [AW-1:0] A_STAT = AW'(ST_ADDR);
    localparam logic [AW-1:0] A_MASK = AW'(MSK_ADDR);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_state_t;

    rd_state_t     rd_d, rd_q;
    logic          wr_stat, wr_mask;
    logic [N_EV-1:0] clr_vec, ev_bits, mask_bits;
    logic          rstat;
    logic [DW-1:0] stat_word, mask_word;

    always_comb begin
        wr_stat = host_wr && (host_addr == A_STAT);
        wr_mask = host_wr && (host_addr == A_MASK);
        clr_vec = wr_stat ? host_wdata[N_EV-1:0] : '0;
    end

    irq_evt_bits #(.N(N_EV)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_val (init_status),
        .set      (evt_set),
        .clr      (clr_vec),
        .bits     (ev_bits)
    );

    irq_rst_flag u_rflag (
        .clk     (clk),
        .rst_n   (rst_n),
        .enter   (ctl_reset_enter),
        .start   (ctl_start),
        .ovf     (ring_overflow),
        .drained (ring_drained),
        .flag    (rstat)
    );

    irq_mask_reg #(.N(N_EV)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_mask),
        .wdata (host_wdata[N_EV-1:0]),
        .mask  (mask_bits)
    );

    always_comb begin
        stat_word = {rstat, ev_bits};
        mask_word = {1'b0, mask_bits};
        rd_d      = rd_q;
        if (host_addr == A_STAT)
            rd_d.rdata = stat_word;
        else if (host_addr == A_MASK)
            rd_d.rdata = mask_word;
        else
            rd_d.rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q.rdata <= '0;
        else
            rd_q <= rd_d;
    end

    assign host_rdata = rd_q.rdata;
    assign irq        = |(ev_bits & mask_bits);

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_bits == '0) |-> !irq);
    p_irq_fall_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(host_wr));
    p_rstat_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bits == '0) |-> !irq);
    p_rd_other_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_addr != A_STAT) && (host_addr != A_MASK)) |=> (host_rdata == '0));
endmodule

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] init_status = 7'h5A;
    logic [6:0] evt_set = '0;
    logic       ctl_reset_enter = 1'b0, ctl_start = 1'b0;
    logic       ring_overflow = 1'b0, ring_drained = 1'b0;
    logic [3:0] host_addr = 4'h0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [6:0] m_ev, m_mask;
    logic       m_b7;
    logic [7:0] m_rd;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .init_status(init_status), .evt_set(evt_set),
        .ctl_reset_enter(ctl_reset_enter), .ctl_start(ctl_start),
        .ring_overflow(ring_overflow), .ring_drained(ring_drained),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Behavioural reference: advance one clock with the inputs now applied.
    task automatic model_step();
        logic [7:0] old_stat;
        integer clrbits;
        old_stat = {m_b7, m_ev};
        if (host_addr == 4'h7) m_rd = old_stat;
        else if (host_addr == 4'hF) m_rd = {1'b0, m_mask};
        else m_rd = 8'h00;
        clrbits = (host_wr && host_addr == 4'h7) ? host_wdata[6:0] : 0;
        for (int i = 0; i < 7; i++) begin
            if (evt_set[i]) m_ev[i] = 1'b1;
            else if (clrbits[i]) m_ev[i] = 1'b0;
        end
        if (ctl_reset_enter || ring_overflow) m_b7 = 1'b1;
        else if (ctl_start || ring_drained) m_b7 = 1'b0;
        if (host_wr && host_addr == 4'hF) m_mask = host_wdata[6:0];
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R1 rdata vs model", host_rdata, m_rd);
        check("R5 irq vs model", {7'b0, irq}, {7'b0, |(m_ev & m_mask)});
    endtask

    task automatic clear_in();
        evt_set = '0; ctl_reset_enter = 0; ctl_start = 0;
        ring_overflow = 0; ring_drained = 0; host_wr = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        host_addr = a; host_wr = 1'b1; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        host_addr = a;
        tick();
        v = host_rdata;
    endtask

    task automatic pulse_evt(input logic [6:0] e);
        evt_set = e; tick(); evt_set = '0;
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        m_ev = 7'h5A; m_mask = '0; m_b7 = 1'b1; m_rd = '0;
        repeat (3) @(negedge clk);
        check("R9 irq in reset", {7'b0, irq}, 8'h00);
        check("R9 rdata in reset", host_rdata, 8'h00);
        rst_n = 1'b1;
        rd(4'h7, v); check("R9 status after reset", v, 8'hDA);
        rd(4'hF, v); check("R9 mask after reset", v, 8'h00);
        check("R9 irq after reset", {7'b0, irq}, 8'h00);

        wr(4'h7, 8'hFF);
        rd(4'h7, v); check("R3 R8 clear all", v, 8'h80);
        pulse_evt(7'h04);
        rd(4'h7, v); check("R2 rx error bit", v, 8'h84);
        wr(4'h7, 8'h00); rd(4'h7, v); check("R3 zero write keeps", v, 8'h84);
        wr(4'h7, 8'h01); rd(4'h7, v); check("R3 other bit keeps", v, 8'h84);
        wr(4'h7, 8'h04); rd(4'h7, v); check("R3 clear bit 2", v, 8'h80);

        wr(4'hF, 8'hFF); rd(4'hF, v); check("R6 mask readback", v, 8'h7F);
        check("R8 bit7 set, all enabled, no irq", {7'b0, irq}, 8'h00);
        pulse_evt(7'h10);
        check("R5 irq on unmasked event", {7'b0, irq}, 8'h01);
        wr(4'hF, 8'h6F);
        check("R6 masking drops irq", {7'b0, irq}, 8'h00);
        wr(4'hF, 8'h7F);
        check("R5 unmask raises irq", {7'b0, irq}, 8'h01);
        wr(4'h7, 8'h10);
        check("R5 irq low after clear", {7'b0, irq}, 8'h00);

        evt_set = 7'h08; wr(4'h7, 8'h08); evt_set = '0;
        rd(4'h7, v); check("R4 set beats clear", v, 8'h88);
        wr(4'h7, 8'h08);

        ctl_start = 1; tick(); ctl_start = 0;
        rd(4'h7, v); check("R7 start clears bit7", v, 8'h00);
        ring_overflow = 1; tick(); ring_overflow = 0;
        rd(4'h7, v); check("R7 overflow sets bit7", v, 8'h80);
        ring_drained = 1; tick(); ring_drained = 0;
        rd(4'h7, v); check("R7 drain clears bit7", v, 8'h00);
        ctl_reset_enter = 1; ctl_start = 1; tick(); clear_in();
        rd(4'h7, v); check("R7 enter beats start", v, 8'h80);
        ring_overflow = 1; ring_drained = 1; tick(); clear_in();
        rd(4'h7, v); check("R7 overflow beats drain", v, 8'h80);
        ctl_start = 1; tick(); clear_in();
        wr(4'h7, 8'h80); rd(4'h7, v); check("R8 write cannot set bit7", v, 8'h00);
        ctl_reset_enter = 1; tick(); clear_in();
        wr(4'h7, 8'hFF); rd(4'h7, v); check("R8 write cannot clear bit7", v, 8'h80);
        rd(4'h3, v); check("R1 unmapped address", v, 8'h00);

        for (int k = 0; k < 4000; k++) begin
            evt_set = ($urandom_range(0, 3) == 0) ? 7'($urandom) : '0;
            ctl_reset_enter = ($urandom_range(0, 15) == 0);
            ctl_start       = ($urandom_range(0, 15) == 0);
            ring_overflow   = ($urandom_range(0, 15) == 0);
            ring_drained    = ($urandom_range(0, 15) == 0);
            case ($urandom_range(0, 3))
                0: host_addr = 4'h7;
                1: host_addr = 4'hF;
                default: host_addr = 4'($urandom);
            endcase
            host_wr    = ($urandom_range(0, 2) == 0);
            host_wdata = 8'($urandom);
            tick();
        end
        clear_in();
        tick();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule